// File: doc/BRIEF.md
# Character display host port

This block models the device side of the host port of a character display controller. A host drives an enable strobe together with a register select (`data_sel`) and a direction bit (`rd_nwr`). On the falling edge of the strobe the block carries out one access. The access writes an instruction, reads the status byte, writes a data byte or reads a data byte. Instructions move a 7-bit address counter, pick between an 80-byte display store and a 64-byte glyph-pattern store, set the entry mode, clear the display or send the cursor home.

The data register does not read storage on demand. It loads a byte ahead of time, after an address set and after every data read. The host then collects that byte on its next data read. A data write leaves the written byte in the data register, so a read that directly follows a write gets that byte back, not the storage content.

Every accepted instruction and data access raises a busy flag for a set number of clock cycles. Clear and home use a long count and everything else uses a short one. The host polls the status byte to learn when the next access will be taken.

Top module: `chardisp_port`

## Requirements
- R1: After reset the status byte reads 0x00 (not busy, counter 0). Every display byte holds 0x20 and every pattern byte holds 0x00. Increment mode, one-line mode, display target and view offset 0 are in force.
- R2: The access type is sampled on the clock edge that sees `strobe` fall. data_sel/rd_nwr = 0/0 writes an instruction, 0/1 is a status read, 1/0 writes data and 1/1 reads data. `bus_out` carries {busy, counter[6:0]} when data_sel=0 and the data register when data_sel=1.
- R3: Instruction 1AAAAAAA loads A into the counter and targets display storage. Instruction 01AAAAAA loads the 6-bit A and targets pattern storage. Both copy the addressed byte into the data register.
- R4: A data read returns the data register. The counter then steps and the data register reloads from the new address. After a data write the data register holds the written byte.
- R5: Entry-mode instruction 000001IS sets increment (I=1) or decrement (I=0) and the shift flag S. Each data access steps the counter by one in that direction. In one-line mode the counter wraps between 0x4F and 0x00, and pattern addresses wrap modulo 64.
- R6: Function-set instruction 001xNxxx selects two-line mode with N=1. In two-line mode display addresses are 0x00–0x27 and 0x40–0x67. Incrementing goes 0x27→0x40 and 0x67→0x00, and decrementing goes the reverse way.
- R7: Instruction 0x01 writes 0x20 to every display byte. It zeroes the counter, forces increment mode, keeps S, zeroes the view offset and targets display storage.
- R8: Instruction 0000001x zeroes the counter and the view offset, targets display storage and leaves storage contents intact.
- R9: While busy, instruction and data accesses have no effect on the counter, the data register or storage.
- R10: Busy rises on the clock edge that accepts an access. It stays high for BUSY_LONG cycles after clear or home and for BUSY_SHORT cycles after any other instruction or data access. Status reads never raise it.
- R11: With S=1, each data write to display storage moves `view_ofs` up by one (increment mode) or down by one (decrement mode). The offset wraps modulo the line length, which is COLS in two-line mode and 2*COLS in one-line mode. Data reads and pattern writes leave the offset alone.
- R12: Display and pattern storage are separate. A write to one never shows in the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| strobe | input | 1 | Access enable; the access executes on its falling edge |
| data_sel | input | 1 | 0 selects instruction/status, 1 selects data |
| rd_nwr | input | 1 | 1 for read, 0 for write |
| bus_in | input | 8 | Write byte from the host |
| bus_out | output | 8 | Status byte or data register |
| busy | output | 1 | Busy flag |
| view_ofs | output | 7 | Current display shift offset |

## Verification
Ascending writes and reads tell a correct step direction apart from a stuck or reversed counter. Descending writes across 0x00 show the one-line wrap and separate it from a plain 7-bit rollover. Writes straddling 0x27 and 0x67 in two-line mode expose a counter that skips the line gap wrongly. Reads right after writes and right after address sets tell the prefetch behaviour apart from a direct storage read. An access issued while busy, followed by a status read and a data read, shows whether the block really dropped it.

// File: rtl/chardisp_port.sv
module chardisp_port #(
  parameter int COLS       = 40,
  parameter int PAT_AW     = 6,
  parameter int BUSY_LONG  = 40,
  parameter int BUSY_SHORT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       data_sel,
  input  logic       rd_nwr,
  input  logic [7:0] bus_in,
  output logic [7:0] bus_out,
  output logic       busy,
  output logic [6:0] view_ofs
);
  localparam int DLEN = 2 * COLS;
  localparam int PLEN = 1 << PAT_AW;
  localparam int DAW  = $clog2(DLEN);
  localparam int CW   = $clog2(BUSY_LONG + 1);
  localparam logic [6:0] L1END  = 7'(COLS - 1);
  localparam logic [6:0] L2BASE = 7'h40;
  localparam logic [6:0] L2END  = 7'(64 + COLS - 1);
  localparam logic [6:0] ONEEND = 7'(DLEN - 1);
  localparam logic [6:0] PMASK  = 7'(PLEN - 1);

  logic [7:0]    dmem [DLEN];
  logic [7:0]    pmem [PLEN];
  logic [6:0]    ac, ofs;
  logic [7:0]    dr;
  logic          inc, shl, two, dsel, strobe_q;
  logic [CW-1:0] cnt;

  function automatic logic dvalid(input logic [6:0] a, input logic tw);
    return tw ? (int'(a[5:0]) < COLS) : (int'(a) < DLEN);
  endfunction

  function automatic logic [DAW-1:0] didx(input logic [6:0] a, input logic tw);
    int v;
    v = tw ? (a[6] ? COLS + int'(a[5:0]) : int'(a[5:0])) : int'(a);
    return DAW'(v);
  endfunction

  function automatic logic [6:0] step(input logic [6:0] a, input logic up,
                                     input logic disp, input logic tw);
    logic [6:0] r;
    if (!disp)
      r = (up ? a + 7'd1 : a - 7'd1) & PMASK;
    else if (tw) begin
      if (up) r = (a == L1END) ? L2BASE : (a == L2END) ? 7'h00 : a + 7'd1;
      else    r = (a == L2BASE) ? L1END : (a == 7'h00) ? L2END : a - 7'd1;
    end else begin
      if (up) r = (a == ONEEND) ? 7'h00 : a + 7'd1;
      else    r = (a == 7'h00) ? ONEEND : a - 7'd1;
    end
    return r;
  endfunction

  function automatic logic [7:0] fetch(input logic [6:0] a, input logic disp, input logic tw);
    if (disp) return dvalid(a, tw) ? dmem[didx(a, tw)] : 8'h00;
    return pmem[a[PAT_AW-1:0]];
  endfunction

  wire        fall   = strobe_q & ~strobe;
  wire        go     = fall & ~busy & (data_sel | ~rd_nwr);
  wire        ins_wr = go & ~data_sel & ~rd_nwr;
  wire        dat_wr = go & data_sel & ~rd_nwr;
  wire        dat_rd = go & data_sel & rd_nwr;
  wire [6:0]  nxt    = step(ac, inc, dsel, two);
  wire [6:0]  span   = two ? 7'(COLS) : 7'(DLEN);
  wire        is_long = (bus_in[7:1] == 7'h01) || (bus_in == 8'h01);
  wire [6:0]  cg_addr = {1'b0, bus_in[5:0]} & PMASK;

  assign busy     = cnt != '0;
  assign bus_out  = data_sel ? dr : {busy, ac};
  assign view_ofs = ofs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DLEN; i++) dmem[i] <= 8'h20;
      for (int i = 0; i < PLEN; i++) pmem[i] <= 8'h00;
      ac       <= '0;
      ofs      <= '0;
      dr       <= '0;
      inc      <= 1'b1;
      shl      <= 1'b0;
      two      <= 1'b0;
      dsel     <= 1'b1;
      strobe_q <= 1'b0;
      cnt      <= '0;
    end else begin
      strobe_q <= strobe;
      if (cnt != '0) cnt <= cnt - CW'(1);

      if (ins_wr) begin
        cnt <= is_long ? CW'(BUSY_LONG) : CW'(BUSY_SHORT);
        casez (bus_in)
          8'b1???????: begin
            ac   <= bus_in[6:0];
            dsel <= 1'b1;
            dr   <= fetch(bus_in[6:0], 1'b1, two);
          end
          8'b01??????: begin
            ac   <= cg_addr;
            dsel <= 1'b0;
            dr   <= fetch(cg_addr, 1'b0, two);
          end
          8'b001?????: two <= bus_in[3];
          8'b000001??: begin
            inc <= bus_in[1];
            shl <= bus_in[0];
          end
          8'b0000001?: begin
            ac   <= '0;
            ofs  <= '0;
            dsel <= 1'b1;
          end
          8'b00000001: begin
            for (int i = 0; i < DLEN; i++) dmem[i] <= 8'h20;
            ac   <= '0;
            ofs  <= '0;
            inc  <= 1'b1;
            dsel <= 1'b1;
          end
          default: ;
        endcase
      end

      if (dat_wr) begin
        cnt <= CW'(BUSY_SHORT);
        dr  <= bus_in;
        ac  <= nxt;
        if (dsel) begin
          if (dvalid(ac, two)) dmem[didx(ac, two)] <= bus_in;
          if (shl) begin
            if (inc) ofs <= (ofs >= span - 7'd1) ? 7'd0 : ofs + 7'd1;
            else     ofs <= (ofs == 7'd0) ? span - 7'd1 : ofs - 7'd1;
          end
        end else begin
          pmem[ac[PAT_AW-1:0]] <= bus_in;
        end
      end

      if (dat_rd) begin
        cnt <= CW'(BUSY_SHORT);
        ac  <= nxt;
        dr  <= fetch(nxt, dsel, two);
      end
    end
  end
endmodule

module chardisp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic       data_sel,
  input logic       rd_nwr,
  input logic [7:0] bus_in,
  input logic       busy,
  input logic [6:0] ac,
  input logic [7:0] dr,
  input logic       inc,
  input logic       dsel
);
  logic s_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) s_q <= 1'b0;
    else        s_q <= strobe;

  wire edge_seen = s_q && !strobe;

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(ac) && $stable(dr)));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !busy && (data_sel || !rd_nwr)) |=> busy);

  // R10
  status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !busy && !data_sel && rd_nwr) |=> (!busy && $stable(ac)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && !busy && !data_sel && !rd_nwr && bus_in == 8'h01) |=> (ac == 7'd0 && inc && dsel));

  // R5
  pattern_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dsel |-> !ac[6]);
endmodule

bind chardisp_port chardisp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .data_sel(data_sel), .rd_nwr(rd_nwr),
  .bus_in(bus_in), .busy(busy), .ac(ac), .dr(dr), .inc(inc), .dsel(dsel)
);

// File: tb/chardisp_port_bench.sv
`timescale 1ns/1ps
module chardisp_port_bench;
  localparam int COLS = 40, BL = 40, BS = 4;

  logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0, data_sel = 1'b0, rd_nwr = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       busy;
  logic [6:0] view_ofs;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  chardisp_port #(.COLS(COLS), .PAT_AW(6), .BUSY_LONG(BL), .BUSY_SHORT(BS)) u_chardisp_port (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .data_sel(data_sel), .rd_nwr(rd_nwr),
    .bus_in(bus_in), .bus_out(bus_out), .busy(busy), .view_ofs(view_ofs));

  localparam logic [1:0] OI = 2'b00, OS = 2'b01, OW = 2'b10, OR = 2'b11;
  // {tag[3:0], data_sel, rd_nwr, bus_in[7:0], check, expected[7:0]}
  localparam int NV = 51;
  localparam logic [22:0] VEC [NV] = '{
    {4'd1,  OS, 8'h00, 1'b1, 8'h00}, // R1 status after reset
    {4'd0,  OI, 8'h85, 1'b0, 8'h00},
    {4'd3,  OS, 8'h00, 1'b1, 8'h05}, // R3 display address loaded
    {4'd0,  OW, 8'h41, 1'b0, 8'h00},
    {4'd0,  OW, 8'h42, 1'b0, 8'h00},
    {4'd5,  OS, 8'h00, 1'b1, 8'h07}, // R5 counter stepped up twice
    {4'd0,  OI, 8'h85, 1'b0, 8'h00},
    {4'd4,  OR, 8'h00, 1'b1, 8'h41}, // R4 prefetched byte
    {4'd4,  OR, 8'h00, 1'b1, 8'h42}, // R4 read-ahead of next byte
    {4'd1,  OR, 8'h00, 1'b1, 8'h20}, // R1 untouched display byte
    {4'd0,  OW, 8'h55, 1'b0, 8'h00},
    {4'd4,  OR, 8'h00, 1'b1, 8'h55}, // R4 stale byte after a write
    {4'd4,  OS, 8'h00, 1'b1, 8'h0A}, // R4 read steps counter
    {4'd0,  OI, 8'h04, 1'b0, 8'h00},
    {4'd0,  OI, 8'h81, 1'b0, 8'h00},
    {4'd0,  OW, 8'h31, 1'b0, 8'h00},
    {4'd0,  OW, 8'h30, 1'b0, 8'h00},
    {4'd5,  OS, 8'h00, 1'b1, 8'h4F}, // R5 one-line wrap down
    {4'd0,  OI, 8'h38, 1'b0, 8'h00},
    {4'd0,  OI, 8'hC0, 1'b0, 8'h00},
    {4'd0,  OW, 8'h61, 1'b0, 8'h00},
    {4'd6,  OS, 8'h00, 1'b1, 8'h27}, // R6 0x40 down to 0x27
    {4'd0,  OI, 8'h06, 1'b0, 8'h00},
    {4'd0,  OI, 8'hA7, 1'b0, 8'h00},
    {4'd0,  OW, 8'h62, 1'b0, 8'h00},
    {4'd6,  OS, 8'h00, 1'b1, 8'h40}, // R6 0x27 up to 0x40
    {4'd0,  OI, 8'hC0, 1'b0, 8'h00},
    {4'd6,  OR, 8'h00, 1'b1, 8'h61}, // R6 second line storage
    {4'd0,  OI, 8'hE7, 1'b0, 8'h00},
    {4'd0,  OW, 8'h63, 1'b0, 8'h00},
    {4'd6,  OS, 8'h00, 1'b1, 8'h00}, // R6 0x67 up to 0x00
    {4'd0,  OI, 8'h7F, 1'b0, 8'h00},
    {4'd0,  OW, 8'h1F, 1'b0, 8'h00},
    {4'd5,  OS, 8'h00, 1'b1, 8'h00}, // R5 pattern wrap modulo 64
    {4'd0,  OI, 8'h7F, 1'b0, 8'h00},
    {4'd12, OR, 8'h00, 1'b1, 8'h1F}, // R12 pattern byte
    {4'd1,  OR, 8'h00, 1'b1, 8'h00}, // R1 pattern reset value
    {4'd0,  OI, 8'h80, 1'b0, 8'h00},
    {4'd12, OR, 8'h00, 1'b1, 8'h30}, // R12 display byte kept
    {4'd0,  OI, 8'h04, 1'b0, 8'h00},
    {4'd0,  OI, 8'h01, 1'b0, 8'h00},
    {4'd7,  OS, 8'h00, 1'b1, 8'h00}, // R7 counter zeroed
    {4'd0,  OW, 8'h77, 1'b0, 8'h00},
    {4'd7,  OS, 8'h00, 1'b1, 8'h01}, // R7 increment forced
    {4'd0,  OI, 8'hC0, 1'b0, 8'h00},
    {4'd7,  OR, 8'h00, 1'b1, 8'h20}, // R7 storage filled
    {4'd0,  OI, 8'h90, 1'b0, 8'h00},
    {4'd0,  OI, 8'h02, 1'b0, 8'h00},
    {4'd8,  OS, 8'h00, 1'b1, 8'h00}, // R8 home zeroes counter
    {4'd0,  OI, 8'h80, 1'b0, 8'h00},
    {4'd8,  OR, 8'h00, 1'b1, 8'h77}  // R8 contents kept
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic s, input logic r, input logic [7:0] d, output logic [7:0] got);
    @(negedge clk);
    data_sel = s; rd_nwr = r; bus_in = d; strobe = 1'b1;
    @(negedge clk);
    got = bus_out;
    strobe = 1'b0;
  endtask

  task automatic settle;
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic op(input logic [1:0] k, input logic [7:0] d, output logic [7:0] got);
    xfer(k[1], k[0], d, got);
    settle();
  endtask

  task automatic busy_len(output int n);
    n = 0;
    @(negedge clk);
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset outputs
    check("R1", {busy, view_ofs}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][18:17], VEC[i][16:9], g);
      if (VEC[i][8]) check($sformatf("R%0d", VEC[i][22:19]), g, VEC[i][7:0]);
    end

    // R10 long busy after home, short after other instructions, none after status
    xfer(1'b0, 1'b0, 8'h02, g); busy_len(n);
    check("R10", 8'(n), 8'(BL));
    xfer(1'b0, 1'b0, 8'h06, g); busy_len(n);
    check("R10", 8'(n), 8'(BS));
    xfer(1'b0, 1'b1, 8'h00, g); busy_len(n);
    check("R10", 8'(n), 8'h00);
    // R2 status byte shows busy on bit 7
    xfer(1'b0, 1'b0, 8'h80, g);
    xfer(1'b0, 1'b1, 8'h00, g);
    check("R2", g, 8'h80);
    settle();

    // R9 data write issued while busy is dropped
    xfer(1'b0, 1'b0, 8'h90, g);
    xfer(1'b1, 1'b0, 8'h99, g);
    settle();
    op(OS, 8'h00, g); check("R9", g, 8'h10);
    op(OR, 8'h00, g); check("R9", g, 8'h20);

    // R11 display shift on writes
    op(OI, 8'h07, g);
    op(OI, 8'h80, g);
    op(OW, 8'h41, g); check("R11", {1'b0, view_ofs}, 8'h01);
    op(OI, 8'h80, g);
    op(OR, 8'h00, g); check("R11", {1'b0, view_ofs}, 8'h01);
    op(OI, 8'h05, g);
    op(OW, 8'h42, g); check("R11", {1'b0, view_ofs}, 8'h00);
    op(OW, 8'h43, g); check("R11", {1'b0, view_ofs}, 8'(COLS - 1));
    op(OI, 8'h40, g);
    op(OW, 8'h0E, g); check("R11", {1'b0, view_ofs}, 8'(COLS - 1));
    op(OI, 8'h02, g); check("R8", {1'b0, view_ofs}, 8'h00);

    // R1 reset in mid-run restores storage
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    check("R1", {busy, view_ofs}, 8'h00);
    op(OS, 8'h00, g); check("R1", g, 8'h00);
    op(OI, 8'h80, g);
    op(OR, 8'h00, g); check("R1", g, 8'h20);
    op(OI, 8'h40, g);
    op(OR, 8'h00, g); check("R1", g, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule